// File: doc/BRIEF.md
# Predicated Vector Loop Step Sequencer

This block is the control sequencer for a vector loop of length VL. It keeps two element indices, a source step and a destination step, and walks each one through its own predicate mask. Elements whose mask bit is clear are passed over. For each element that survives, the block presents the final step pair and raises a one-cycle issue request. It then waits for a completion strobe from the execution side. When the loop finishes, whether an element was issued on the last pass or not, it emits a one-cycle loop-done pulse.

A loop starts with a start strobe, which carries VL and the predication setup. In twin mode the source and destination masks are independent. In single mode the source mask steers both steps. Each mask can be flagged as "always", which means all ones and no fetch. Any mask that is not "always" is requested over a level request / valid port and captured on the valid cycle. Decode, execution and register access are left to the surrounding logic. The step outputs are stable for the whole issue and wait period of each element.

Top module: `vloop_seq`

## Requirements
- R1: After reset, both step outputs are 0 and issue_o, loop_done_o and mask_req_o are 0. A start with VL of 0 gives loop_done_o in the next cycle, with no issue and no mask request.
- R2: A mask whose "always" flag is set is not fetched and acts as all ones. With both effective masks "always", elements 0..VL-1 are issued in order with equal steps, and mask_req_o never rises.
- R3: When a mask needs fetching, mask_req_o stays high from the cycle after start until the cycle in which mask_valid_i is sampled high. The mask words are captured only in that cycle; their values at other times have no effect.
- R4: Before each issue, each step advances past the clear bits of its own mask, in a single skip step. Bit i of a mask word belongs to element i (bit 0 is element 0). The step values shown with issue_o always index set bits of their masks.
- R5: In twin mode (twin_i=1) the source and destination steps follow src_mask_i/src_all_i and dst_mask_i/dst_all_i independently. In single mode (twin_i=0) the source mask drives both steps; dst_mask_i and dst_all_i are ignored.
- R6: The loop ends as soon as either step would reach VL, whether by skipping or by advancing after a completion. No element is issued with a step at or above VL, and the destination step never exceeds VL-1.
- R7: When the remaining mask bits below VL are all clear, the loop still ends with a loop_done_o pulse and no issue on that pass. An all-zero mask gives no issue at all.
- R8: issue_o and loop_done_o are each one cycle wide. When the completion of an element ends the loop, loop_done_o is high in the cycle right after the cycle in which done_i was sampled.
- R9: After each completion that does not end the loop, both steps advance by one and the current bit of each mask is consumed, before the next skip.
- R10: start_i is ignored while a loop is running. done_i is ignored unless the block is waiting for a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| vl_i | input | IDX_W | Loop length 0..MASK_W, sampled with start |
| twin_i | input | 1 | 1 = twin predication, 0 = single |
| src_all_i | input | 1 | Source mask is all ones, no fetch |
| dst_all_i | input | 1 | Destination mask is all ones, no fetch (twin only) |
| mask_req_o | output | 1 | Mask fetch request, held until valid |
| mask_valid_i | input | 1 | Mask words valid this cycle |
| src_mask_i | input | MASK_W | Source predicate word |
| dst_mask_i | input | MASK_W | Destination predicate word |
| src_step_o | output | IDX_W | Current source element index |
| dst_step_o | output | IDX_W | Current destination element index |
| issue_o | output | 1 | One-cycle element issue request |
| done_i | input | 1 | Element completion strobe |
| loop_done_o | output | 1 | One-cycle loop completion pulse |

## Verification
Several properties are checked on every cycle. Each issue lands on set mask bits with both steps below VL, and the destination step stays within VL-1. Issue and loop-done are single pulses. The request is held until valid, and a consumed bit is always a set bit. Other behaviour shows only across whole loops, so the bench scenarios compare against a model: the exact sequence of step pairs in twin and single modes, and the final step values. They also cover the immediate end for VL of 0 and for masks with no usable bits, the loop-done timing after the last completion, and the cases where a stray start or completion must be ignored.

// File: rtl/vloop_pkg.sv
package vloop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SKIP,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } seq_state_e;

  localparam int NUM_LANES = 2;
  localparam int LANE_SRC  = 0;
  localparam int LANE_DST  = 1;
endpackage

// File: rtl/vloop_ctz.sv
module vloop_ctz #(
  parameter int W = 64
) (
  input  logic [W-1:0]             vec_i,
  output logic [$clog2(W+1)-1:0]   cnt_o
);
  localparam int CW = $clog2(W+1);

  // lowest set bit wins; W when empty
  always_comb begin
    cnt_o = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) cnt_o = CW'(i);
    end
  end
endmodule

// File: rtl/vloop_lane.sv
module vloop_lane #(
  parameter int W = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     load_i,
  input  logic [W-1:0]             load_val_i,
  input  logic                     skip_i,
  input  logic                     cons_i,
  output logic [$clog2(W+1)-1:0]   step_o,
  output logic [$clog2(W+1)-1:0]   gap_o,
  output logic                     empty_o,
  output logic                     head_o
);
  localparam int SW = $clog2(W+1);

  logic [W-1:0]  mask_q;
  logic [SW-1:0] step_q;

  vloop_ctz #(.W(W)) u_ctz (
    .vec_i (mask_q),
    .cnt_o (gap_o)
  );

  // mask_q bit 0 is aligned with step_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      step_q <= '0;
    end else if (clr_i) begin
      mask_q <= '1;
      step_q <= '0;
    end else if (load_i) begin
      mask_q <= load_val_i;
    end else if (skip_i) begin
      mask_q <= mask_q >> gap_o;
      step_q <= step_q + gap_o;
    end else if (cons_i) begin
      mask_q <= mask_q >> 1;
      step_q <= step_q + SW'(1);
    end
  end

  assign step_o  = step_q;
  assign empty_o = (mask_q == '0);
  assign head_o  = mask_q[0];

  // R9
  consume_set_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cons_i |-> head_o);

  // R4
  skip_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_i |=> head_o);
endmodule

// File: rtl/vloop_seq.sv
module vloop_seq #(
  parameter int MASK_W = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [$clog2(MASK_W+1)-1:0]   vl_i,
  input  logic                          twin_i,
  input  logic                          src_all_i,
  input  logic                          dst_all_i,
  output logic                          mask_req_o,
  input  logic                          mask_valid_i,
  input  logic [MASK_W-1:0]             src_mask_i,
  input  logic [MASK_W-1:0]             dst_mask_i,
  output logic [$clog2(MASK_W+1)-1:0]   src_step_o,
  output logic [$clog2(MASK_W+1)-1:0]   dst_step_o,
  output logic                          issue_o,
  input  logic                          done_i,
  output logic                          loop_done_o
);
  import vloop_pkg::*;

  localparam int IDX_W = $clog2(MASK_W+1);
  localparam int SUM_W = IDX_W + 1;

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] vl_q;
  logic             twin_q;
  logic             need_src_q, need_dst_q;

  logic [IDX_W-1:0]  step  [NUM_LANES];
  logic [IDX_W-1:0]  gap   [NUM_LANES];
  logic [MASK_W-1:0] lval  [NUM_LANES];
  logic              empty [NUM_LANES];
  logic              head  [NUM_LANES];
  logic              load  [NUM_LANES];
  logic              reach [NUM_LANES];
  logic              edge_hit [NUM_LANES];

  logic clr, fetch_ack, skip_end, skip_go, last, cons, need_fetch_d;

  assign clr       = (state_q == ST_IDLE) && start_i;
  assign fetch_ack = (state_q == ST_FETCH) && mask_valid_i;

  assign lval[LANE_SRC] = src_mask_i;
  assign lval[LANE_DST] = twin_q ? dst_mask_i : src_mask_i;
  assign load[LANE_SRC] = fetch_ack && need_src_q;
  assign load[LANE_DST] = fetch_ack && need_dst_q;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    vloop_lane #(.W(MASK_W)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr),
      .load_i     (load[g]),
      .load_val_i (lval[g]),
      .skip_i     (skip_go),
      .cons_i     (cons),
      .step_o     (step[g]),
      .gap_o      (gap[g]),
      .empty_o    (empty[g]),
      .head_o     (head[g])
    );
    // skip would land at or past VL
    assign reach[g]    = (SUM_W'(step[g]) + SUM_W'(gap[g])) >= SUM_W'(vl_q);
    // advancing by one would hit VL
    assign edge_hit[g] = (SUM_W'(step[g]) + SUM_W'(1)) >= SUM_W'(vl_q);
  end

  assign skip_end = empty[LANE_SRC] || empty[LANE_DST] || reach[LANE_SRC] || reach[LANE_DST];
  assign skip_go  = (state_q == ST_SKIP) && !skip_end;
  assign last     = edge_hit[LANE_SRC] || edge_hit[LANE_DST];
  assign cons     = (state_q == ST_WAIT) && done_i && !last;

  assign need_fetch_d = !src_all_i || (twin_i && !dst_all_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (vl_i == '0)        state_d = ST_FIN;
          else if (need_fetch_d) state_d = ST_FETCH;
          else                   state_d = ST_SKIP;
        end
      end
      ST_FETCH: if (mask_valid_i) state_d = ST_SKIP;
      ST_SKIP:  state_d = skip_end ? ST_FIN : ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:  if (done_i) state_d = last ? ST_FIN : ST_SKIP;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      vl_q       <= '0;
      twin_q     <= 1'b0;
      need_src_q <= 1'b0;
      need_dst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clr) begin
        vl_q       <= vl_i;
        twin_q     <= twin_i;
        need_src_q <= !src_all_i;
        need_dst_q <= twin_i ? !dst_all_i : !src_all_i;
      end
    end
  end

  assign mask_req_o  = (state_q == ST_FETCH);
  assign issue_o     = (state_q == ST_ISSUE);
  assign loop_done_o = (state_q == ST_FIN);
  assign src_step_o  = step[LANE_SRC];
  assign dst_step_o  = step[LANE_DST];

  // R6
  issue_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (src_step_o < vl_q) && (dst_step_o < vl_q));

  // R6
  dst_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vl_q != '0) |-> (dst_step_o < vl_q));

  // R4
  issue_on_set_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> head[LANE_SRC] && head[LANE_DST]);

  // R8
  issue_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> !issue_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_done_o |=> !loop_done_o);

  // R8
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WAIT) && done_i && last) |=> loop_done_o);

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_req_o && !mask_valid_i) |=> mask_req_o);

  // R1
  zero_vl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && start_i && (vl_i == '0)) |=> loop_done_o && !mask_req_o);
endmodule

// File: tb/tb_vloop_seq.sv
module tb_vloop_seq;
  localparam int MW = 64;
  localparam int IW = $clog2(MW+1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [IW-1:0] vl_i = '0;
  logic          twin_i = 1'b0, src_all_i = 1'b0, dst_all_i = 1'b0;
  logic          mask_req_o, mask_valid_i = 1'b0;
  logic [MW-1:0] src_mask_i = '0, dst_mask_i = '0;
  logic [IW-1:0] src_step_o, dst_step_o;
  logic          issue_o, done_i = 1'b0, loop_done_o;

  int checks = 0;
  int failures = 0;

  int exp_s [64];
  int exp_d [64];
  int exp_n, fin_s, fin_d;
  bit end_done;

  always #4 clk_i = ~clk_i;

  vloop_seq #(.MASK_W(MW)) dut (
    .clk_i, .rst_ni, .start_i, .vl_i, .twin_i, .src_all_i, .dst_all_i,
    .mask_req_o, .mask_valid_i, .src_mask_i, .dst_mask_i,
    .src_step_o, .dst_step_o, .issue_o, .done_i, .loop_done_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ctz(input logic [63:0] m);
    for (int i = 0; i < 64; i++) if (m[i]) return i;
    return 64;
  endfunction

  // loop model from the requirements
  task automatic model(input int vl, input bit twin, input bit sa, input bit da,
                       input logic [63:0] sm, input logic [63:0] dm);
    logic [63:0] ms, md;
    int s, d, ts, td;
    ms = sa ? '1 : sm;
    md = twin ? (da ? '1 : dm) : ms;
    s = 0; d = 0; exp_n = 0; end_done = 0;
    if (vl != 0) begin
      forever begin
        if (ms == 0 || md == 0) break;
        ts = ctz(ms); td = ctz(md);
        if (s + ts >= vl || d + td >= vl) break;
        s += ts; d += td; ms = ms >> ts; md = md >> td;
        exp_s[exp_n] = s; exp_d[exp_n] = d; exp_n++;
        if (s + 1 >= vl || d + 1 >= vl) begin end_done = 1; break; end
        s++; d++; ms = ms >> 1; md = md >> 1;
      end
    end
    fin_s = s; fin_d = d;
  endtask

  task automatic run(input int vl, input bit twin, input bit sa, input bit da,
                     input logic [63:0] sm, input logic [63:0] dm, input bit poke);
    int k, cyc, dcnt, mcnt, last_done;
    bit fin, seen_req, need;
    model(vl, twin, sa, da, sm, dm);
    need = (vl != 0) && (!sa || (twin && !da));
    k = 0; cyc = 0; dcnt = -1; mcnt = -1; last_done = -10; fin = 0; seen_req = 0;
    @(negedge clk_i);
    start_i = 1'b1; vl_i = IW'(vl); twin_i = twin; src_all_i = sa; dst_all_i = da;
    while (!fin && cyc < 4000) begin
      @(negedge clk_i);
      cyc++;
      start_i = 1'b0; done_i = 1'b0; mask_valid_i = 1'b0;
      src_mask_i = {$urandom, $urandom}; dst_mask_i = {$urandom, $urandom};
      if (mask_req_o) begin
        seen_req = 1;
        if (mcnt < 0) mcnt = $urandom % 3;
        if (mcnt == 0) begin
          mask_valid_i = 1'b1; src_mask_i = sm; dst_mask_i = dm; mcnt = -1;
        end else mcnt--;
      end
      if (issue_o) begin
        // R4 R5 R2
        if (k < exp_n) begin
          chk(src_step_o == IW'(exp_s[k]), "R4", "src step at issue", src_step_o, exp_s[k]);
          chk(dst_step_o == IW'(exp_d[k]), "R5", "dst step at issue", dst_step_o, exp_d[k]);
        end else chk(0, "R6", "extra issue", k, exp_n);
        k++;
        dcnt = (poke ? 1 : 0) + int'($urandom % 3);
        if (poke && k == 1) begin
          // R10 stray start and early completion
          start_i = 1'b1; vl_i = '0; done_i = 1'b1;
        end
      end else if (dcnt >= 0) begin
        if (dcnt == 0) begin done_i = 1'b1; last_done = cyc; dcnt = -1; end
        else dcnt--;
      end
      if (loop_done_o) fin = 1;
    end
    chk(fin, "R7", "loop done seen", fin, 1);
    chk(k == exp_n, "R6", "issue count", k, exp_n);
    chk(seen_req == need, "R3", "mask request seen", seen_req, need);
    chk(src_step_o == IW'(fin_s), "R9", "final src step", src_step_o, fin_s);
    chk(dst_step_o == IW'(fin_d), "R6", "final dst step", dst_step_o, fin_d);
    if (vl == 0) chk(cyc == 1, "R1", "zero vl done cycle", cyc, 1);
    if (end_done) chk(last_done == cyc - 1, "R8", "done after last completion", last_done, cyc - 1);
    @(negedge clk_i);
    chk(loop_done_o == 1'b0, "R8", "loop done width", loop_done_o, 0);
    chk(issue_o == 1'b0, "R10", "idle after loop", issue_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(src_step_o == 0 && dst_step_o == 0, "R1", "reset steps", src_step_o, 0);
    chk(!issue_o && !loop_done_o && !mask_req_o, "R1", "reset strobes", issue_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run(0, 1, 0, 0, 64'hFF, 64'hFF, 0);                           // R1
    run(64, 1, 1, 1, 0, 0, 0);                                     // R2 full loop
    run(5, 0, 1, 0, 0, 64'h0, 0);                                  // R2 R5 dst ignored
    run(10, 1, 0, 0, 64'h0, 64'hFFFF, 0);                          // R7 all zero
    run(8, 1, 0, 0, 64'h0000_0100_0000_0005, 64'h3, 0);            // R7 bits past VL
    run(16, 1, 0, 1, 64'h0000_0000_0000_A5A5, 0, 0);               // twin compress
    run(16, 1, 1, 0, 0, 64'h0000_0000_0000_9249, 0);               // twin expand
    run(12, 0, 0, 1, 64'h0000_0000_0000_0891, 64'h0, 0);           // R5 single
    run(20, 1, 0, 0, 64'h8000_0000_000F_F0F0, 64'h0000_0000_0000_0FFF, 1); // R10
    run(64, 1, 0, 0, 64'h8000_0000_0000_0001, 64'hC000_0000_0000_0000, 0); // R6 edge
    for (int n = 0; n < 60; n++) begin
      int vl;
      logic [63:0] sm, dm;
      vl = int'($urandom % 65);
      sm = {$urandom, $urandom};
      dm = {$urandom, $urandom};
      if (n % 3 == 1) begin sm &= {$urandom, $urandom}; dm &= {$urandom, $urandom}; end
      if (n % 3 == 2) begin sm |= {$urandom, $urandom}; end
      run(vl, $urandom % 2, ($urandom % 4) == 0, ($urandom % 4) == 0, sm, dm, n % 7 == 3);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule